// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a synchronous host and an asynchronous byte-wide static RAM of 128K locations. The host raises a one-cycle request with a write flag, an address and write data. The controller then plays out a fixed pin sequence on the memory: address, two chip selects of opposite polarity, an active-low output enable and an active-low write enable. When the sequence is over it pulses a done strobe.

Every pin phase lasts a whole number of clock cycles. Each count is derived at elaboration from the clock period and the nanosecond limits of the memory speed grade, rounded up, with a floor of one cycle. A write has one setup cycle with the chip selected, then a write-strobe pulse, then one hold cycle with the chip still selected. The write therefore ends on the rising edge of the write strobe, while address and data are still stable. A read holds output enable low until the access time has elapsed and samples the bus on that clock edge. It then parks the chip deselected for a recovery interval, so the memory has released the bus before the controller can drive it.

The data bus is brought out as a separate output value, drive enable and input value, so a pad ring or a bench can form the tri-state.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: During and after reset with no request, the chip is deselected: `mem_ce1_n`=1 and `mem_ce2`=0. Also `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0, `done`=0 and `rd_data`=0.
- R2: An accepted write (`wr`=1) selects the chip (`mem_ce1_n`=0, `mem_ce2`=1) for one cycle with `mem_we_n`=1. Then `mem_we_n`=0 for N_WP cycles (2 at defaults). Then there is one more selected cycle with `mem_we_n`=1. The address stays constant for the whole time the chip is selected.
- R3: `mem_dq_oe` is 1 only while `mem_we_n`=0 and `mem_oe_n`=1. While it is 1, `mem_dq_o` carries the write data of the accepted request.
- R4: A byte written to an address is returned on `rd_data` by a later read of that address.
- R5: An accepted read (`wr`=0) holds the chip selected with `mem_oe_n`=0 and `mem_we_n`=1 for N_RD cycles (3 at defaults). `rd_data` takes the bus value present on the last clock edge of that window.
- R6: After a read, the chip is deselected with `mem_oe_n`=1 for N_TA cycles (1 at defaults) before the controller returns to idle. As a result, `mem_dq_oe` never rises in the cycle right after `mem_oe_n` was low.
- R7: `done` is 1 for exactly one cycle, the first idle cycle after an operation. At defaults this is the fifth cycle after the accepting edge, for both reads and writes.
- R8: A request raised while an operation is in progress is ignored. The pins follow the running operation, and the memory is not written.
- R9: `rd_data` changes only when a read completes. It holds its value across writes and idle time.
- R10: A request raised in the cycle where `done` is 1 is accepted at once. Consecutive operations need no extra idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Operation request, sampled only while idle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 17 | Word address |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Last byte read, registered |
| done | output | 1 | One-cycle completion strobe |
| mem_addr | output | 17 | Memory address pins |
| mem_ce1_n | output | 1 | Active-low chip select |
| mem_ce2 | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_dq_o | output | 8 | Data value to drive on the bus |
| mem_dq_oe | output | 1 | Bus drive enable |
| mem_dq_i | input | 8 | Data value seen on the bus |

## Verification
The assertions check the pin-ordering rules on every cycle:
- the bus is driven only inside the write-strobe pulse, with output enable high;
- the write strobe is bracketed by selected cycles on both edges;
- the address is frozen while the chip is selected;
- the bus is never driven right after output enable was low;
- the done strobe lasts one cycle;
- read data moves only when a read completes.

The bench's scenarios show the rest:
- the exact phase lengths;
- that sampling happens no earlier than the access time, through a memory model that returns garbage until then;
- that data actually lands in and comes back from the memory;
- that requests made while busy are dropped;
- that back-to-back operations are accepted.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WSETUP,
        PH_WPULSE,
        PH_WHOLD,
        PH_RACCESS,
        PH_RRECOVER
    } phase_e;

    // ceil(ns / period), never below one cycle
    function automatic int ns_to_cyc(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_pin_decode.sv
module sram_pin_decode
    import sram_ctrl_pkg::*;
(
    input  phase_e ph,
    output logic   ce1_n,
    output logic   ce2,
    output logic   oe_n,
    output logic   we_n,
    output logic   dq_oe
);
    logic selected;

    always_comb begin
        selected = (ph == PH_WSETUP) || (ph == PH_WPULSE) ||
                   (ph == PH_WHOLD)  || (ph == PH_RACCESS);
        ce1_n    = ~selected;
        ce2      = selected;
        oe_n     = (ph != PH_RACCESS);
        we_n     = (ph != PH_WPULSE);
        dq_oe    = (ph == PH_WPULSE);
    end
endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int DATA_W   = 8,
    parameter int CLK_NS   = 20,
    parameter int T_ACC_NS = 55,
    parameter int T_OE_NS  = 25,
    parameter int T_WC_NS  = 55,
    parameter int T_PWE_NS = 40,
    parameter int T_AW_NS  = 50,
    parameter int T_DS_NS  = 25,
    parameter int T_HZ_NS  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce1_n,
    output logic              mem_ce2,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_i
);
    // read window: later of address access and output-enable access
    localparam int N_RD  = imax(ns_to_cyc(T_ACC_NS, CLK_NS), ns_to_cyc(T_OE_NS, CLK_NS));
    // strobe width: pulse, data setup, address setup (one setup cycle precedes), cycle time (setup+hold)
    localparam int N_WP0 = imax(imax(ns_to_cyc(T_PWE_NS, CLK_NS), ns_to_cyc(T_DS_NS, CLK_NS)),
                                imax(ns_to_cyc(T_AW_NS, CLK_NS) - 1, ns_to_cyc(T_WC_NS, CLK_NS) - 2));
    localparam int N_WP  = imax(N_WP0, 1);
    localparam int N_TA  = ns_to_cyc(T_HZ_NS, CLK_NS);
    localparam int CNT_W = imax($clog2(imax(imax(N_RD, N_WP), N_TA) + 1), 1);

    typedef struct packed {
        phase_e            ph;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              done;
    } ctrl_t;

    ctrl_t            st_d, st_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;

    sram_phase_timer #(.W(CNT_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        case (st_q.ph)
            PH_IDLE: begin
                if (req) begin
                    st_d.addr  = addr;
                    st_d.wdata = wr_data;
                    if (wr) begin
                        st_d.ph = PH_WSETUP;
                    end else begin
                        st_d.ph  = PH_RACCESS;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(N_RD - 1);
                    end
                end
            end
            PH_WSETUP: begin
                st_d.ph  = PH_WPULSE;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(N_WP - 1);
            end
            PH_WPULSE: begin
                if (tmr_zero) st_d.ph = PH_WHOLD;
            end
            PH_WHOLD: begin
                st_d.ph   = PH_IDLE;
                st_d.done = 1'b1;
            end
            PH_RACCESS: begin
                if (tmr_zero) begin
                    st_d.rdata = mem_dq_i;
                    st_d.ph    = PH_RRECOVER;
                    tmr_load   = 1'b1;
                    tmr_val    = CNT_W'(N_TA - 1);
                end
            end
            PH_RRECOVER: begin
                if (tmr_zero) begin
                    st_d.ph   = PH_IDLE;
                    st_d.done = 1'b1;
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, addr: '0, wdata: '0, rdata: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    sram_pin_decode i_pins (
        .ph    (st_q.ph),
        .ce1_n (mem_ce1_n),
        .ce2   (mem_ce2),
        .oe_n  (mem_oe_n),
        .we_n  (mem_we_n),
        .dq_oe (mem_dq_oe)
    );

    assign mem_addr = st_q.addr;
    assign mem_dq_o = st_q.wdata;
    assign rd_data  = st_q.rdata;
    assign done     = st_q.done;

    logic sel;
    assign sel = !mem_ce1_n && mem_ce2;

    p_dq_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n && mem_oe_n));
    p_we_needs_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> sel);
    p_we_fall_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> $past(sel));
    p_we_rise_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> sel);
    p_addr_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && $past(sel)) |-> $stable(mem_addr));
    p_turnaround_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> $past(mem_oe_n));
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data) |-> $past(!mem_oe_n));
endmodule

// File: tb/test_sram_cycle_ctrl.sv
module test_sram_cycle_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, wr = 1'b0;
    logic [16:0] addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic        done;
    logic [16:0] mem_addr;
    logic        mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_o;
    logic [7:0]  mem_dq_i = 8'hEE;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sram_cycle_ctrl i_sram_cycle_ctrl (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .done(done), .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n),
        .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    // memory device model and expected contents
    logic [7:0] dev_mem[int];
    logic [7:0] exp_mem[int];
    int         acc_cnt = 0;
    logic [16:0] last_a = '0;
    logic       prev_we_n = 1'b1;
    logic [7:0] last_dq = '0;

    // reference timeline of the current operation
    bit          ref_act = 0;
    int          ref_t = 0;
    bit          ref_wr = 0;
    logic [16:0] ref_a = '0;
    logic [7:0]  ref_d = '0;
    logic [7:0]  exp_rd = '0;
    string       scen = "reset";

    function automatic logic [7:0] dflt(input logic [16:0] a);
        return a[7:0] ^ 8'hA5;
    endfunction

    function automatic logic [7:0] exp_at(input logic [16:0] a);
        return exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : dflt(a);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s [%s] t=%0d actual=%h expected=%h", tag, scen, ref_t, act, exp);
        end
    endtask

    task automatic compare();
        logic e_sel, e_oen, e_wen, e_dqoe, e_done;
        string tag;
        e_sel = 0; e_oen = 1; e_wen = 1; e_dqoe = 0; e_done = 0; tag = "R1";
        if (ref_act) begin
            if (ref_wr) begin
                case (ref_t)
                    1: begin e_sel = 1; tag = "R2"; end
                    2, 3: begin e_sel = 1; e_wen = 0; e_dqoe = 1; tag = "R3"; end
                    4: begin e_sel = 1; tag = "R2"; end
                    5: begin e_done = 1; tag = "R7"; end
                    default: ;
                endcase
            end else begin
                case (ref_t)
                    1, 2, 3: begin e_sel = 1; e_oen = 0; tag = "R5"; end
                    4: begin tag = "R6"; exp_rd = exp_at(ref_a); end
                    5: begin e_done = 1; tag = "R7"; end
                    default: ;
                endcase
            end
        end
        chk(tag, {26'd0, mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe, done},
                 {26'd0, ~e_sel, e_sel, e_oen, e_wen, e_dqoe, e_done});
        if (e_sel) chk("R2", 32'(mem_addr), 32'(ref_a));
        if (e_dqoe) chk("R3", 32'(mem_dq_o), 32'(ref_d));
        chk((ref_act && !ref_wr && ref_t >= 4) ? "R4" : "R9", 32'(rd_data), 32'(exp_rd));
    endtask

    task automatic device();
        logic sel;
        sel = !mem_ce1_n && mem_ce2;
        if (!prev_we_n && mem_we_n && sel) dev_mem[int'(mem_addr)] = last_dq;
        if (!mem_we_n && mem_dq_oe) last_dq = mem_dq_o;
        prev_we_n = mem_we_n;
        if (sel && !mem_oe_n && mem_we_n) begin
            if (acc_cnt > 0 && mem_addr == last_a) acc_cnt++;
            else acc_cnt = 1;
            last_a = mem_addr;
        end else begin
            acc_cnt = 0;
        end
        // valid only once the access window has fully elapsed
        if (acc_cnt >= 3)
            mem_dq_i = dev_mem.exists(int'(mem_addr)) ? dev_mem[int'(mem_addr)] : dflt(mem_addr);
        else
            mem_dq_i = 8'hEE;
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
        if (ref_act) ref_t++;
        compare();
        device();
    endtask

    // one operation; optional stray request presented before tick ign (2..5)
    task automatic run_op(input bit w, input logic [16:0] a, input logic [7:0] d,
                          input int ign, input bit ign_w, input logic [16:0] ign_a,
                          input logic [7:0] ign_d);
        req = 1; wr = w; addr = a; wr_data = d;
        ref_act = 1; ref_t = 0; ref_wr = w; ref_a = a; ref_d = d;
        if (w) exp_mem[int'(a)] = d;
        tick();
        for (int k = 2; k <= 5; k++) begin
            if (k == ign) begin
                req = 1; wr = ign_w; addr = ign_a; wr_data = ign_d;
            end else begin
                req = 0;
            end
            tick();
        end
        req = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #100000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        scen = "reset R1";
        idle(3);
        rst_n = 1;
        idle(2);

        scen = "write R2 R3";
        run_op(1, 17'h00010, 8'h3C, 0, 0, '0, '0);
        scen = "back-to-back readback R10 R4";
        run_op(0, 17'h00010, 8'h00, 0, 0, '0, '0);
        scen = "read unwritten top address R5";
        run_op(0, 17'h1FFFF, 8'h00, 0, 0, '0, '0);
        scen = "write top address R2";
        run_op(1, 17'h1FFFF, 8'hC3, 0, 0, '0, '0);
        scen = "write address zero R3";
        run_op(1, 17'h00000, 8'h81, 0, 0, '0, '0);
        scen = "read top address R4";
        run_op(0, 17'h1FFFF, 8'h00, 0, 0, '0, '0);
        idle(2);
        scen = "read address zero R4";
        run_op(0, 17'h00000, 8'h00, 0, 0, '0, '0);

        scen = "stray write during write R8 R9";
        run_op(1, 17'h00020, 8'h77, 2, 1, 17'h00030, 8'h99);
        scen = "stray write during hold R8";
        run_op(1, 17'h00040, 8'h55, 5, 1, 17'h00050, 8'h11);
        idle(3);
        scen = "stray write during read R8";
        run_op(0, 17'h00020, 8'h00, 3, 1, 17'h00060, 8'h22);
        scen = "stray write during recovery R8 R6";
        run_op(0, 17'h00040, 8'h00, 5, 1, 17'h00070, 8'h33);
        scen = "check stray targets untouched R8";
        run_op(0, 17'h00030, 8'h00, 0, 0, '0, '0);
        run_op(0, 17'h00050, 8'h00, 0, 0, '0, '0);
        run_op(0, 17'h00060, 8'h00, 0, 0, '0, '0);
        run_op(0, 17'h00070, 8'h00, 0, 0, '0, '0);
        scen = "read then write turnaround R6 R10";
        run_op(0, 17'h00010, 8'h00, 0, 0, '0, '0);
        run_op(1, 17'h00010, 8'hA0, 0, 0, '0, '0);
        run_op(0, 17'h00010, 8'h00, 0, 0, '0, '0);
        scen = "idle hold R9 R1";
        ref_act = 0;
        idle(4);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule